// File: doc/BRIEF.md
# Parallel Sort-and-Merge Array

This block takes four independent streams of small unsigned numbers and returns all of them as one list, ordered from largest to smallest. Each stream has its own valid bit and feeds its own insertion chain of compare-and-keep cells. Every cell holds the larger of its current value and the arriving one, and passes the smaller one to the next cell a cycle later. The chain therefore stays sorted while values are still arriving. Up to `LIST_DEPTH` values per stream make up one sort.

When every valid bit has been low for `LIST_DEPTH` consecutive cycles, the block treats the batch as complete and enters a drain phase. A tree of three two-input merge nodes sits on the four chain heads. At each node the larger head goes forward, and the left input wins a tie. The root pops one element per cycle into the output register, and `out_valid` marks each real element. When all chains are empty the block goes back to accepting input. The user must keep inputs idle for the whole drain. At most `4 * LIST_DEPTH` elements are emitted, so the drain lasts at most `LIST_DEPTH + 1 + 4 * LIST_DEPTH` cycles after the last valid set.

Top module: `sort_merge_array`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `out_valid` is low. Values accepted before a reset never appear at the output afterwards.
- R2: The output list of one batch is the multiset of all values accepted in that batch, ordered so that no element is greater than the element before it.
- R3: Each of the four streams accepts up to `LIST_DEPTH` (default 5) values, independently of the other streams. Valid sets may be separated by idle gaps shorter than `LIST_DEPTH` cycles, and such gaps do not split the batch.
- R4: The first element of a batch is present on `out_valid`/`out_data` after the sixth rising clock edge (`LIST_DEPTH + 1`) that follows the edge which sampled the last valid set.
- R5: A batch of N elements raises `out_valid` for exactly N consecutive cycles, with no gaps. Cycles that carry no element never show `out_valid` high.
- R6: A data lane whose valid bit is low has no effect on the output, whatever its value.
- R7: Valid inputs presented while a batch is draining are discarded. They do not appear in the output and do not start a new batch.
- R8: When no valid input has been seen since reset or since the last drain, no element is emitted.
- R9: A value of zero that was accepted with its valid bit high is emitted as a valid element.
- R10: After a drain completes, a new batch is accepted and sorted with no reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset that empties every cell and clears all state |
| in_valid | input | 4 | Per-stream valid; bit s qualifies lane s of `in_data` |
| in_data | input | 16 | Four 4-bit unsigned lanes; lane s is bits [4s+3:4s] |
| out_valid | output | 1 | High on each cycle that carries a sorted element |
| out_data | output | 4 | Current sorted element, largest first |

## Verification
A cell that keeps the wrong value of a compare, or a merge node that routes a pop to the wrong child, shows up in the output list as an element out of order, a missing element, a duplicate, or a stale element. It appears within at most twenty cycles of the drain starting. A wrong idle counter or phase register shows up as a shift of the first output element away from the sixth edge after the last valid set. It can also show up as a batch split in two, or as a gap inside the valid run. The bench compares every batch, element by element, against a list it sorts itself, and checks the arrival cycle of each element.

// File: rtl/sortmerge_pkg.sv
package sortmerge_pkg;

    localparam int unsigned SM_DW        = 4;
    localparam int unsigned SM_STREAMS   = 4;
    localparam int unsigned SM_DEPTH_DEF = 5;

    typedef struct packed {
        logic             v;
        logic [SM_DW-1:0] d;
    } elem_t;

    localparam elem_t ELEM_NONE = '{v: 1'b0, d: '0};

    typedef enum logic [0:0] {
        SM_FILL  = 1'b0,
        SM_DRAIN = 1'b1
    } phase_t;

    // Left head is chosen when it is valid and not smaller than the right one.
    function automatic logic take_left(elem_t l, elem_t r);
        return l.v && (!r.v || (l.d >= r.d));
    endfunction

endpackage

// File: rtl/sm_cell.sv
module sm_cell
    import sortmerge_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fill_en,
    input  logic  pop,
    input  elem_t ins,
    input  elem_t below,
    output elem_t held,
    output elem_t pass
);

    elem_t held_q;
    elem_t pass_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= ELEM_NONE;
            pass_q <= ELEM_NONE;
        end else if (pop) begin
            held_q <= below;
            pass_q <= ELEM_NONE;
        end else if (fill_en && ins.v) begin
            if (!held_q.v) begin
                held_q <= ins;
                pass_q <= ELEM_NONE;
            end else if (ins.d > held_q.d) begin
                held_q <= ins;
                pass_q <= held_q;
            end else begin
                pass_q <= ins;
            end
        end else begin
            pass_q <= ELEM_NONE;
        end
    end

    assign held = held_q;
    assign pass = pass_q;

    // R3: an empty cell absorbs what it receives and spills nothing downstream
    a_r3_empty_cell_no_spill: assert property (@(posedge clk) disable iff (rst)
        !held_q.v |=> !pass_q.v);

endmodule

// File: rtl/sm_stream_sorter.sv
module sm_stream_sorter
    import sortmerge_pkg::*;
#(
    parameter int unsigned DEPTH = SM_DEPTH_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fill_en,
    input  logic  pop,
    input  elem_t ins,
    output elem_t head
);

    elem_t held  [DEPTH];
    elem_t pass  [DEPTH];
    elem_t feed  [DEPTH];
    elem_t below [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        if (i == 0) begin : g_first
            assign feed[i] = ins;
        end else begin : g_next
            assign feed[i] = pass[i-1];
        end

        if (i == DEPTH - 1) begin : g_tail
            assign below[i] = ELEM_NONE;
        end else begin : g_mid
            assign below[i] = held[i+1];
        end

        sm_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .fill_en (fill_en),
            .pop     (pop),
            .ins     (feed[i]),
            .below   (below[i]),
            .held    (held[i]),
            .pass    (pass[i])
        );

        if (i < DEPTH - 1) begin : g_order_chk
            // R2: the chain stays sorted, filled from the head, at every cycle
            a_r2_chain_sorted: assert property (@(posedge clk) disable iff (rst)
                held[i+1].v |-> (held[i].v && (held[i].d >= held[i+1].d)));
        end
    end

    assign head = held[0];

    // R3: within the stated batch size the last cell never has to drop a value
    a_r3_depth_bound: assert property (@(posedge clk) disable iff (rst)
        !pass[DEPTH-1].v);

endmodule

// File: rtl/sm_merge.sv
module sm_merge
    import sortmerge_pkg::*;
(
    input  elem_t left,
    input  elem_t right,
    input  logic  pop,
    output elem_t head,
    output logic  pop_l,
    output logic  pop_r
);

    logic pick_l;

    always_comb begin
        pick_l = take_left(left, right);
        head   = pick_l ? left : right;
        pop_l  = pop && pick_l;
        pop_r  = pop && !pick_l && right.v;
    end

endmodule

// File: rtl/sort_merge_array.sv
module sort_merge_array
    import sortmerge_pkg::*;
#(
    parameter int unsigned LIST_DEPTH = SM_DEPTH_DEF
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [SM_STREAMS-1:0]          in_valid,
    input  logic [SM_STREAMS*SM_DW-1:0]    in_data,
    output logic                           out_valid,
    output logic [SM_DW-1:0]               out_data
);

    localparam int unsigned CNT_W = $clog2(LIST_DEPTH + 1);
    localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(LIST_DEPTH - 1);
    localparam int unsigned PAIRS = SM_STREAMS / 2;

    phase_t           phase_q;
    logic             seen_q;
    logic [CNT_W-1:0] idle_q;

    logic  fill_en;
    logic  root_pop;
    elem_t leaf_head [SM_STREAMS];
    logic  leaf_pop  [SM_STREAMS];
    elem_t mid_head  [PAIRS];
    logic  mid_pop   [PAIRS];
    elem_t root_head;

    assign fill_en  = (phase_q == SM_FILL);
    assign root_pop = (phase_q == SM_DRAIN) && root_head.v;

    for (genvar s = 0; s < SM_STREAMS; s++) begin : g_stream
        elem_t lane;
        assign lane = '{v: in_valid[s], d: in_data[s*SM_DW +: SM_DW]};

        sm_stream_sorter #(.DEPTH(LIST_DEPTH)) u_sorter (
            .clk     (clk),
            .rst     (rst),
            .fill_en (fill_en),
            .pop     (leaf_pop[s]),
            .ins     (lane),
            .head    (leaf_head[s])
        );
    end

    for (genvar m = 0; m < PAIRS; m++) begin : g_mid
        sm_merge u_node (
            .left  (leaf_head[2*m]),
            .right (leaf_head[2*m+1]),
            .pop   (mid_pop[m]),
            .head  (mid_head[m]),
            .pop_l (leaf_pop[2*m]),
            .pop_r (leaf_pop[2*m+1])
        );
    end

    sm_merge u_root (
        .left  (mid_head[0]),
        .right (mid_head[1]),
        .pop   (root_pop),
        .head  (root_head),
        .pop_l (mid_pop[0]),
        .pop_r (mid_pop[1])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= SM_FILL;
            seen_q    <= 1'b0;
            idle_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            unique case (phase_q)
                SM_FILL: begin
                    out_valid <= 1'b0;
                    if (|in_valid) begin
                        seen_q <= 1'b1;
                        idle_q <= '0;
                    end else if (seen_q) begin
                        if (idle_q == IDLE_LAST) begin
                            phase_q <= SM_DRAIN;
                            seen_q  <= 1'b0;
                            idle_q  <= '0;
                        end else begin
                            idle_q <= idle_q + 1'b1;
                        end
                    end
                end
                SM_DRAIN: begin
                    out_valid <= root_head.v;
                    if (root_head.v) begin
                        out_data <= root_head.d;
                    end else begin
                        phase_q <= SM_FILL;
                    end
                end
                default: phase_q <= SM_FILL;
            endcase
        end
    end

    // R2: consecutive output elements never increase
    a_r2_out_descending: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_data <= $past(out_data)));

    // R2: the root head dominates both first-level heads
    a_r2_root_dominates: assert property (@(posedge clk) disable iff (rst)
        root_head.v |-> ((!mid_head[0].v || root_head.d >= mid_head[0].d) &&
                         (!mid_head[1].v || root_head.d >= mid_head[1].d)));

    // R5: once a valid run ends, the next cycle is quiet as well
    a_r5_run_unbroken: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |=> !out_valid);

    // R7: outside the drain phase no element is launched
    a_r7_quiet_outside_drain: assert property (@(posedge clk) disable iff (rst)
        (phase_q != SM_DRAIN) |=> !out_valid);

endmodule

// File: tb/sort_merge_array_tb.sv
module sort_merge_array_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  in_valid = '0;
    logic [15:0] in_data  = '0;
    logic        out_valid;
    logic [3:0]  out_data;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;

    int vals [4][5];
    int cnt  [4];
    int gap  = 0;
    bit junk = 1'b0;

    int cap_d [64];
    int cap_c [64];
    int ncap = 0;

    always #2 clk = ~clk;

    sort_merge_array u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (ncap < 64) begin
                cap_d[ncap] = int'(out_data);
                cap_c[ncap] = cyc;
            end
            ncap = ncap + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic idle_cycle();
        in_valid = '0;
        in_data  = 16'($urandom);
        @(negedge clk);
    endtask

    task automatic run_session(input string req);
        int exp [20];
        int n = 0;
        int last = -1;
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < cnt[s]; k++) begin
                exp[n] = vals[s][k];
                n++;
            end
        for (int a = 0; a < n; a++)
            for (int b = 0; b + 1 < n - a; b++)
                if (exp[b] < exp[b+1]) begin
                    int t = exp[b];
                    exp[b] = exp[b+1];
                    exp[b+1] = t;
                end
        ncap = 0;
        for (int k = 0; k < 5; k++) begin
            if (k > 0) repeat (gap) idle_cycle();
            for (int s = 0; s < 4; s++) begin
                in_valid[s] = (k < cnt[s]);
                in_data[s*4 +: 4] = (k < cnt[s]) ? 4'(vals[s][k]) : 4'($urandom);
            end
            @(negedge clk);
            if (k < cnt[0] || k < cnt[1] || k < cnt[2] || k < cnt[3]) last = cyc;
        end
        for (int i = 0; i < 40; i++) begin
            if (junk && last >= 0 && (cyc == last + 6 || cyc == last + 7)) begin
                in_valid = 4'hF;
                in_data  = 16'hFFFF;
                @(negedge clk);
            end else begin
                idle_cycle();
            end
        end
        chk(ncap == n, {req, " element count (R5)"}, ncap, n);
        for (int j = 0; j < n && j < ncap; j++)
            chk(cap_d[j] == exp[j], {req, " element value"}, cap_d[j], exp[j]);
        if (n > 0 && ncap > 0) begin
            chk(cap_c[0] == last + 6, "R4 first element latency", cap_c[0], last + 6);
            for (int j = 1; j < n && j < ncap; j++)
                chk(cap_c[j] == cap_c[0] + j, "R5 contiguous run", cap_c[j], cap_c[0] + j);
        end
    endtask

    task automatic clear_batch();
        for (int s = 0; s < 4; s++) begin
            cnt[s] = 0;
            for (int k = 0; k < 5; k++) vals[s][k] = 0;
        end
        gap  = 0;
        junk = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid during reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        // R8: idle with garbage data emits nothing
        ncap = 0;
        repeat (30) idle_cycle();
        chk(ncap == 0, "R8 no output without valid input", ncap, 0);

        // R9: all zeros, full batch
        clear_batch();
        for (int s = 0; s < 4; s++) cnt[s] = 5;
        run_session("R9");
        for (int j = 0; j < ncap && j < 64; j++)
            chk(cap_d[j] == 0, "R9 zero element", cap_d[j], 0);

        // R3: one stream, ascending arrival
        clear_batch();
        cnt[0] = 5;
        for (int k = 0; k < 5; k++) vals[0][k] = k + 3;
        run_session("R3");

        // R3: uneven streams with gaps
        clear_batch();
        cnt[1] = 2; cnt[2] = 5; cnt[3] = 1;
        vals[1][0] = 7;  vals[1][1] = 7;
        vals[2][0] = 1;  vals[2][1] = 15; vals[2][2] = 7; vals[2][3] = 0; vals[2][4] = 9;
        vals[3][0] = 12;
        gap = 4;
        run_session("R3");

        // R2: full batch, duplicates and extremes
        clear_batch();
        for (int s = 0; s < 4; s++) begin
            cnt[s] = 5;
            for (int k = 0; k < 5; k++) vals[s][k] = (s * 7 + k * 11) % 16;
        end
        run_session("R2");

        // R6: sparse valid with garbage lanes and gaps
        clear_batch();
        cnt[0] = 1; cnt[3] = 3;
        vals[0][0] = 4; vals[3][0] = 2; vals[3][1] = 14; vals[3][2] = 4;
        gap = 3;
        run_session("R6");

        // R7: valid input during drain is dropped
        clear_batch();
        for (int s = 0; s < 4; s++) begin
            cnt[s] = 3;
            for (int k = 0; k < 3; k++) vals[s][k] = (s + 5 * k) % 10;
        end
        junk = 1'b1;
        run_session("R7");

        // R10: next batch straight after a drain
        clear_batch();
        cnt[2] = 4;
        for (int k = 0; k < 4; k++) vals[2][k] = 15 - 2 * k;
        run_session("R10");

        // R1: reset in the middle of a batch discards it
        in_valid = 4'hF;
        in_data  = 16'hFFFF;
        @(negedge clk);
        in_valid = 4'hF;
        in_data  = 16'hEEEE;
        @(negedge clk);
        rst = 1'b1;
        idle_cycle();
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        idle_cycle();
        rst = 1'b0;
        clear_batch();
        cnt[1] = 2; vals[1][0] = 1; vals[1][1] = 2;
        run_session("R1");

        // R2: sweep of random batches
        for (int t = 0; t < 150; t++) begin
            clear_batch();
            for (int s = 0; s < 4; s++) begin
                cnt[s] = int'($urandom % 6);
                for (int k = 0; k < 5; k++) vals[s][k] = int'($urandom % 16);
            end
            gap = int'($urandom % 4);
            run_session("R2");
        end

        finish_run();
    end

endmodule